// File: doc/BRIEF.md
# Graceful Stop and Poll Controller

This block times two things next to a DMA engine: the completion of a graceful stop on the transmit and receive paths, and the periodic prompts that make the transmit engine walk its first descriptor ring. It watches the DMA control register. The register itself lives outside the block. The block sees the register's current value and a strobe that marks each write. The transmit and receive datapaths also drive "frame in progress" flags into the block. A stop request made while a path is idle completes at once. A stop request made during a frame completes only when that frame ends. Each completion is a one-cycle pulse that the interrupt event logic captures.

The poll timer restarts on every control write that leaves the wait-on-poll bit clear. It counts a programmable period of `poll_period_m1 + 1` clock cycles and then re-arms itself. On each expiry it issues a one-cycle walk request, unless a transmit graceful stop is set. For the nominal 100 Hz poll rate, set `poll_period_m1` to f_clk/100 - 1.

Top module: `gspc_ctrl`

## Requirements
- R1: A control write with the receive-stop bit (bit 2) at 1, made while `rx_busy` is low, makes `rx_stop_done` high for exactly one cycle, in the cycle after the write.
- R2: If `rx_busy` is high when the receive-stop bit is written as 1, `rx_stop_done` stays low while `rx_busy` stays high. It then pulses for one cycle in the cycle after `rx_busy` falls.
- R3: The transmit-stop bit (bit 3) works with `tx_busy` and `tx_stop_done` in the same way as R1 and R2 describe for the receive path. A stop on one path never pulses the other path's completion output.
- R4: A deferred stop whose stop bit has been cleared by a later write before the frame ends produces no completion pulse.
- R5: A control write with the wait-on-poll bit (bit 6) at 0 starts the poll timer. `walk_req` then pulses for one cycle `poll_period_m1 + 2` cycles after the write cycle, and again every `poll_period_m1 + 1` cycles after that.
- R6: A control write with wait-on-poll at 0 made while the timer is running restarts the count from the beginning. No walk request is issued in the cycle after that write.
- R7: While the transmit-stop bit is 1, the timer keeps running but `walk_req` stays low.
- R8: While wait-on-poll is 1, the timer is held stopped and `walk_req` stays low, also after the bit is set by a write in mid-period.
- R9: Reset drives all outputs low, drops any deferred stop, and leaves the poll timer stopped until the next control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe of the DMA control register |
| ctrl_value | input | CTRL_W | Current (just written) control register value |
| tx_busy | input | 1 | Transmit frame in progress |
| rx_busy | input | 1 | Receive frame in progress |
| poll_period_m1 | input | PERIOD_W | Poll period in clock cycles, minus one |
| tx_stop_done | output | 1 | Transmit graceful stop complete pulse |
| rx_stop_done | output | 1 | Receive graceful stop complete pulse |
| walk_req | output | 1 | Request to walk transmit ring 0 |

## Verification
Stop requests are applied on each path while it is idle and while it is busy. A busy case is cancelled before its frame ends, and a case is cut by reset. Together these separate the immediate, deferred, cancelled and cleared outcomes, and they show that the two paths never cross. The poll period is swept over every value from 0 to 5. The first and second intervals are measured, which catches off-by-one errors in arming and in re-arming. A mid-period rewrite, a transmit stop, and the wait bit set in mid-period are each used to tell restarting apart from suppressing and from stopping.

// File: rtl/gspc_pkg.sv
package gspc_pkg;
   localparam int unsigned LANES   = 2;
   localparam int unsigned LANE_RX = 0;
   localparam int unsigned LANE_TX = 1;
endpackage

// File: rtl/gspc_stop_lane.sv
module gspc_stop_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic stop_bit,
   input  logic busy,
   output logic done
);
   logic pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (wr) begin
            if (stop_bit) begin
               if (busy) begin
                  pending <= 1'b1;
               end else begin
                  pending <= 1'b0;
                  done    <= 1'b1;
               end
            end else begin
               pending <= 1'b0;
            end
         end else if (pending) begin
            if (!stop_bit) begin
               pending <= 1'b0;
            end else if (!busy) begin
               pending <= 1'b0;
               done    <= 1'b1;
            end
         end
      end
   end

   // R1 / R3: idle stop completes next cycle
   a_r1_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
      wr && stop_bit && !busy |=> done);
   // R2: busy stop is deferred
   a_r2_defer: assert property (@(posedge clk) disable iff (!rst_n)
      wr && stop_bit && busy |=> !done);
   // R2: completion only when the path was idle
   a_r2_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(!busy));
   // R4: a cleared stop bit cancels the deferred completion
   a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_bit |=> !done);
endmodule

// File: rtl/gspc_poll_timer.sv
module gspc_poll_timer #(
   parameter int unsigned PERIOD_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic                wait_bit,
   input  logic                hold_walk,
   input  logic [PERIOD_W-1:0] period_m1,
   output logic                walk
);
   logic                running;
   logic [PERIOD_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
         walk    <= 1'b0;
      end else begin
         walk <= 1'b0;
         if (wait_bit) begin
            running <= 1'b0;
         end else if (wr) begin
            running <= 1'b1;
            cnt     <= period_m1;
         end else if (running) begin
            if (cnt == '0) begin
               walk <= !hold_walk;
               cnt  <= period_m1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R8: no walk while the wait bit holds the timer
   a_r8_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      wait_bit |=> !walk);
   // R7: no walk while the transmit stop is set
   a_r7_tx_stop: assert property (@(posedge clk) disable iff (!rst_n)
      hold_walk |=> !walk);
   // R6: a restart never coincides with a walk
   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> !walk);
endmodule

// File: rtl/gspc_ctrl.sv
module gspc_ctrl #(
   parameter int unsigned CTRL_W      = 32,
   parameter int unsigned RX_STOP_POS = 2,
   parameter int unsigned TX_STOP_POS = 3,
   parameter int unsigned WAIT_POS    = 6,
   parameter int unsigned PERIOD_W    = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctrl_wr,
   input  logic [CTRL_W-1:0]   ctrl_value,
   input  logic                tx_busy,
   input  logic                rx_busy,
   input  logic [PERIOD_W-1:0] poll_period_m1,
   output logic                tx_stop_done,
   output logic                rx_stop_done,
   output logic                walk_req
);
   import gspc_pkg::*;

   if (RX_STOP_POS >= CTRL_W || TX_STOP_POS >= CTRL_W || WAIT_POS >= CTRL_W) begin : g_bad_pos
      $error("gspc_ctrl: control bit position outside register width");
   end
   if (RX_STOP_POS == TX_STOP_POS || RX_STOP_POS == WAIT_POS || TX_STOP_POS == WAIT_POS) begin : g_bad_overlap
      $error("gspc_ctrl: control bit positions must differ");
   end
   if (PERIOD_W < 1) begin : g_bad_period
      $error("gspc_ctrl: PERIOD_W must be at least 1");
   end

   logic [LANES-1:0] lane_busy;
   logic [LANES-1:0] lane_stop;
   logic [LANES-1:0] lane_done;

   assign lane_busy[LANE_RX] = rx_busy;
   assign lane_busy[LANE_TX] = tx_busy;
   assign lane_stop[LANE_RX] = ctrl_value[RX_STOP_POS];
   assign lane_stop[LANE_TX] = ctrl_value[TX_STOP_POS];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      gspc_stop_lane u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (ctrl_wr),
         .stop_bit (lane_stop[g]),
         .busy     (lane_busy[g]),
         .done     (lane_done[g])
      );
   end

   assign rx_stop_done = lane_done[LANE_RX];
   assign tx_stop_done = lane_done[LANE_TX];

   gspc_poll_timer #(.PERIOD_W(PERIOD_W)) u_poll (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (ctrl_wr),
      .wait_bit  (ctrl_value[WAIT_POS]),
      .hold_walk (ctrl_value[TX_STOP_POS]),
      .period_m1 (poll_period_m1),
      .walk      (walk_req)
   );

   // R3: a stop on one path does not pulse the other path
   a_r3_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && !ctrl_value[TX_STOP_POS] |=> !tx_stop_done);
endmodule

// File: tb/gspc_ctrl_tb_top.sv
module gspc_ctrl_tb_top;
   localparam int CLK_P = 10;
   localparam int PW    = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctrl_wr = 1'b0;
   logic [31:0]   ctrl_value = '0;
   logic          tx_busy = 1'b0;
   logic          rx_busy = 1'b0;
   logic [PW-1:0] period = '0;
   logic          tx_done, rx_done, walk;

   int total = 0;
   int bad   = 0;

   always #(CLK_P/2) clk = ~clk;

   gspc_ctrl #(.PERIOD_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_value(ctrl_value),
      .tx_busy(tx_busy), .rx_busy(rx_busy), .poll_period_m1(period),
      .tx_stop_done(tx_done), .rx_stop_done(rx_done), .walk_req(walk));

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wr_ctrl(input logic rx, input logic tx, input logic wt);
      ctrl_value = '0;
      ctrl_value[2] = rx;
      ctrl_value[3] = tx;
      ctrl_value[6] = wt;
      ctrl_wr = 1'b1;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      chk("R9 reset walk", walk, 1'b0);
      chk("R9 reset rx_done", rx_done, 1'b0);
      chk("R9 reset tx_done", tx_done, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 immediate rx stop
      wr_ctrl(1, 0, 1);
      chk("R1 rx done pulse", rx_done, 1'b1);
      chk("R3 no tx cross", tx_done, 1'b0);
      @(negedge clk);
      chk("R1 rx single pulse", rx_done, 1'b0);

      // R3 immediate tx stop
      wr_ctrl(0, 1, 1);
      chk("R3 tx done pulse", tx_done, 1'b1);
      chk("R3 no rx cross", rx_done, 1'b0);
      @(negedge clk);
      chk("R3 tx single pulse", tx_done, 1'b0);

      // R2 deferred rx stop
      rx_busy = 1'b1;
      wr_ctrl(1, 0, 1);
      chk("R2 deferred while busy", rx_done, 1'b0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R2 hold while busy", rx_done, 1'b0);
      end
      rx_busy = 1'b0;
      @(negedge clk);
      chk("R2 done after frame end", rx_done, 1'b1);
      @(negedge clk);
      chk("R2 single pulse", rx_done, 1'b0);

      // R3 deferred tx stop
      tx_busy = 1'b1;
      wr_ctrl(0, 1, 1);
      chk("R3 tx deferred", tx_done, 1'b0);
      tx_busy = 1'b0;
      @(negedge clk);
      chk("R3 tx done after frame", tx_done, 1'b1);
      chk("R3 rx quiet", rx_done, 1'b0);

      // R4 cancelled deferred stop
      rx_busy = 1'b1;
      wr_ctrl(1, 0, 1);
      @(negedge clk);
      wr_ctrl(0, 0, 1);
      rx_busy = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R4 no done after cancel", rx_done, 1'b0);
      end

      // R5 period sweep: first and second interval
      for (int p = 0; p <= 5; p++) begin
         period = p[PW-1:0];
         wr_ctrl(0, 0, 0);
         chk("R6 no walk after write", walk, 1'b0);
         for (int rep = 0; rep < 2; rep++) begin
            for (int i = 1; i <= p + 1; i++) begin
               @(negedge clk);
               chk("R5 walk timing", walk, (i == p + 1));
            end
         end
      end

      // R6 restart mid-period
      period = 8'd4;
      wr_ctrl(0, 0, 0);
      repeat (2) @(negedge clk);
      wr_ctrl(0, 0, 0);
      chk("R6 restart no walk", walk, 1'b0);
      for (int i = 1; i <= 5; i++) begin
         @(negedge clk);
         chk("R6 walk after restart", walk, (i == 5));
      end

      // R7 tx stop suppresses walks
      wr_ctrl(0, 1, 0);
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         chk("R7 no walk in tx stop", walk, 1'b0);
      end

      // R8 wait bit set mid-period stops timer
      period = 8'd2;
      wr_ctrl(0, 0, 0);
      @(negedge clk);
      wr_ctrl(0, 0, 1);
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         chk("R8 no walk while waiting", walk, 1'b0);
      end

      // R9 reset drops pending stop and stops timer
      wr_ctrl(0, 0, 0);
      rx_busy = 1'b1;
      wr_ctrl(1, 0, 0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rx_busy = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk("R9 no done after reset", rx_done, 1'b0);
         chk("R9 timer stopped after reset", walk, 1'b0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule